// File: doc/BRIEF.md
# Packed Dual-Halfword Media ALU

This execution unit performs packed SIMD arithmetic and data-rearrangement operations on two 32-bit source words. Each word is read either as two signed 16-bit lanes or as four 8-bit lanes, depending on the operation.

A 4-bit opcode selects one operation. A separate 4-bit immediate supplies the shift distance for the lane shift. When `in_valid` is high, the selected result is captured into an output register. `out_valid` follows one cycle later. A pipeline stage places this unit behind its operand read, and its registered result feeds the writeback path.

The lane arithmetic covers wrapping and saturating add/subtract, signed min/max, arithmetic right shift and a two-tap signed dot product. The byte-wise unsigned multiply keeps only the upper half of each product. The rearranging operations are halfword pack, byte interleave and byte reversal. The unit also provides a leading-equal-bit count and a zero-conditional select.

Top module: `media_simd_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_result` is 0.
- R2: An operation presented with `in_valid` high appears on `out_result` with `out_valid` high after the next rising clock edge. A cycle with `in_valid` low drives `out_valid` to 0 and leaves `out_result` unchanged.
- R3: Opcodes 0 (add) and 2 (subtract) act on each 16-bit lane (upper = bits 31:16, lower = bits 15:0) and wrap modulo 2^16. Opcodes 1 (add) and 3 (subtract) clamp each lane to [-32768, 32767].
- R4: Opcode 4 returns the signed minimum of each 16-bit lane pair. Opcode 5 returns the signed maximum.
- R5: Opcode 6 shifts each 16-bit lane of `src_a` right arithmetically by `shamt` (0..15), filling with the lane's sign. No bit passes between lanes.
- R6: Opcode 7 returns the 32-bit two's-complement value of upper(a)*upper(b) + lower(a)*lower(b), where all four lanes are signed 16-bit values.
- R7: Opcode 8 multiplies each of the four unsigned byte pairs. It places bits 15:8 of each product in the same byte lane of the result.
- R8: Opcode 9 returns {a[31:16], b[31:16]}. Opcode 10 returns {a[15:0], b[15:0]}.
- R9: Opcode 11 returns {a[31:24], b[31:24], a[23:16], b[23:16]}. Opcode 12 returns {a[15:8], b[15:8], a[7:0], b[7:0]}.
- R10: Opcode 13 returns the number of bit positions, counted downward from bit 31, in which `src_a` and `src_b` agree before the first difference. The count is 32 when the words are identical.
- R11: Opcode 14 returns `src_a` with its four bytes in reverse order.
- R12: Opcode 15 returns 0 when `src_a` is zero, and otherwise returns `src_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 4 | Operation select (encodings in the requirements) |
| shamt | input | 4 | Lane shift distance for opcode 6 |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| out_valid | output | 1 | `out_result` holds a fresh result |
| out_result | output | 32 | Registered operation result |

## Verification
Every operation shares a single register stage, so each result is due exactly one rising edge after the cycle in which its operands are accepted. The bench drives operands and `in_valid` on a falling edge and holds them through one rising edge. It then drops `in_valid` and compares `out_result` and `out_valid` on the following falling edge, halfway between edges. The idle-cycle checks wait several further edges with changed operands before confirming that the held result is unchanged and `out_valid` is low.

// File: rtl/media_simd_alu.sv
module media_simd_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  opcode,
  input  logic [3:0]  shamt,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic        out_valid,
  output logic [31:0] out_result
);

  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_ADDS  = 4'd1;
  localparam logic [3:0] OP_SUB   = 4'd2;
  localparam logic [3:0] OP_SUBS  = 4'd3;
  localparam logic [3:0] OP_MIN   = 4'd4;
  localparam logic [3:0] OP_MAX   = 4'd5;
  localparam logic [3:0] OP_ASR   = 4'd6;
  localparam logic [3:0] OP_DOT   = 4'd7;
  localparam logic [3:0] OP_QMULH = 4'd8;
  localparam logic [3:0] OP_PKHI  = 4'd9;
  localparam logic [3:0] OP_PKLO  = 4'd10;
  localparam logic [3:0] OP_MGHI  = 4'd11;
  localparam logic [3:0] OP_MGLO  = 4'd12;
  localparam logic [3:0] OP_LSAME = 4'd13;
  localparam logic [3:0] OP_BSWAP = 4'd14;
  localparam logic [3:0] OP_ZSEL  = 4'd15;

  function automatic logic [15:0] clamp16(input logic [16:0] v);
    if (v[16] != v[15]) return v[16] ? 16'h8000 : 16'h7FFF;
    return v[15:0];
  endfunction

  logic signed [15:0] a_hi, a_lo, b_hi, b_lo;
  assign a_hi = src_a[31:16];
  assign a_lo = src_a[15:0];
  assign b_hi = src_b[31:16];
  assign b_lo = src_b[15:0];

  logic [16:0] add_hi, add_lo, sub_hi, sub_lo;
  assign add_hi = {a_hi[15], a_hi} + {b_hi[15], b_hi};
  assign add_lo = {a_lo[15], a_lo} + {b_lo[15], b_lo};
  assign sub_hi = {a_hi[15], a_hi} - {b_hi[15], b_hi};
  assign sub_lo = {a_lo[15], a_lo} - {b_lo[15], b_lo};

  logic [15:0] min_hi, min_lo, max_hi, max_lo;
  assign min_hi = (a_hi < b_hi) ? a_hi : b_hi;
  assign min_lo = (a_lo < b_lo) ? a_lo : b_lo;
  assign max_hi = (a_hi < b_hi) ? b_hi : a_hi;
  assign max_lo = (a_lo < b_lo) ? b_lo : a_lo;

  logic signed [15:0] asr_hi, asr_lo;
  assign asr_hi = a_hi >>> shamt;
  assign asr_lo = a_lo >>> shamt;

  logic signed [31:0] prod_hi, prod_lo;
  logic [31:0] dot_sum;
  assign prod_hi = a_hi * b_hi;
  assign prod_lo = a_lo * b_lo;
  assign dot_sum = prod_hi + prod_lo;

  logic [31:0] qmul_hi;
  for (genvar g = 0; g < 4; g++) begin : g_byte_mul
    logic [15:0] bprod;
    assign bprod = src_a[8*g +: 8] * src_b[8*g +: 8];
    assign qmul_hi[8*g +: 8] = bprod[15:8];
  end

  logic [31:0] diff;
  logic [5:0]  same_cnt;
  assign diff = src_a ^ src_b;
  always_comb begin
    same_cnt = 6'd32;
    for (int i = 0; i < 32; i++)
      if (diff[i]) same_cnt = 6'(31 - i);
  end

  logic [31:0] result_d;
  always_comb begin
    unique case (opcode)
      OP_ADD:   result_d = {add_hi[15:0], add_lo[15:0]};
      OP_ADDS:  result_d = {clamp16(add_hi), clamp16(add_lo)};
      OP_SUB:   result_d = {sub_hi[15:0], sub_lo[15:0]};
      OP_SUBS:  result_d = {clamp16(sub_hi), clamp16(sub_lo)};
      OP_MIN:   result_d = {min_hi, min_lo};
      OP_MAX:   result_d = {max_hi, max_lo};
      OP_ASR:   result_d = {asr_hi, asr_lo};
      OP_DOT:   result_d = dot_sum;
      OP_QMULH: result_d = qmul_hi;
      OP_PKHI:  result_d = {src_a[31:16], src_b[31:16]};
      OP_PKLO:  result_d = {src_a[15:0], src_b[15:0]};
      OP_MGHI:  result_d = {src_a[31:24], src_b[31:24], src_a[23:16], src_b[23:16]};
      OP_MGLO:  result_d = {src_a[15:8], src_b[15:8], src_a[7:0], src_b[7:0]};
      OP_LSAME: result_d = {26'd0, same_cnt};
      OP_BSWAP: result_d = {src_a[7:0], src_a[15:8], src_a[23:16], src_a[31:24]};
      OP_ZSEL:  result_d = (src_a == 32'd0) ? 32'd0 : src_b;
      default:  result_d = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= 32'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= result_d;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_result)));

  assert_sat_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_ADDS && !src_a[31] && !src_b[31]) |=> !out_result[31]);

  assert_pack_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_PKHI) |=> out_result[31:16] == $past(src_a[31:16]));

  assert_equal_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_LSAME && src_a == src_b) |=> out_result == 32'd32);

  assert_swap_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_BSWAP) |=> out_result[31:24] == $past(src_a[7:0]));

  assert_zero_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OP_ZSEL && src_a == 32'd0) |=> out_result == 32'd0);

endmodule

// File: tb/media_simd_alu_tb.sv
`timescale 1ns/1ps
module media_simd_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic [3:0]  shamt = 4'd0;
  logic [31:0] src_a = 32'd0;
  logic [31:0] src_b = 32'd0;
  logic        out_valid;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  media_simd_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .shamt(shamt), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_result(out_result)
  );

  // {req, opcode, shamt, a, b, expected}
  localparam int NV = 22;
  localparam logic [107:0] VEC [NV] = '{
    {4'd3,  4'd0,  4'd0,  32'h7FFF0001, 32'h0001FFFF, 32'h80000000}, // R3 wrap add
    {4'd3,  4'd1,  4'd0,  32'h7FFF0001, 32'h0001FFFF, 32'h7FFF0000}, // R3 sat add high clamp
    {4'd3,  4'd2,  4'd0,  32'h80000005, 32'h00010007, 32'h7FFFFFFE}, // R3 wrap sub
    {4'd3,  4'd3,  4'd0,  32'h80000005, 32'h00010007, 32'h8000FFFE}, // R3 sat sub low clamp
    {4'd3,  4'd1,  4'd0,  32'h80004000, 32'hFFFF4000, 32'h80007FFF}, // R3 sat add both ends
    {4'd4,  4'd4,  4'd0,  32'hFFFE0003, 32'h00010005, 32'hFFFE0003}, // R4 min
    {4'd4,  4'd5,  4'd0,  32'hFFFE0003, 32'h00010005, 32'h00010005}, // R4 max
    {4'd5,  4'd6,  4'd4,  32'h80007FF0, 32'h12345678, 32'hF80007FF}, // R5 shift 4
    {4'd5,  4'd6,  4'd15, 32'h80004000, 32'h00000000, 32'hFFFF0000}, // R5 shift 15
    {4'd6,  4'd7,  4'd0,  32'h0003FFFE, 32'h00040005, 32'h00000002}, // R6 mixed signs
    {4'd6,  4'd7,  4'd0,  32'h80008000, 32'h80008000, 32'h80000000}, // R6 extreme
    {4'd7,  4'd8,  4'd0,  32'hFF800210, 32'hFF02FF10, 32'hFE010101}, // R7
    {4'd8,  4'd9,  4'd0,  32'hAABBCCDD, 32'h11223344, 32'hAABB1122}, // R8 high
    {4'd8,  4'd10, 4'd0,  32'hAABBCCDD, 32'h11223344, 32'hCCDD3344}, // R8 low
    {4'd9,  4'd11, 4'd0,  32'hAABB1122, 32'hCCDD3344, 32'hAACCBBDD}, // R9 high
    {4'd9,  4'd12, 4'd0,  32'hAABB1122, 32'hCCDD3344, 32'h11332244}, // R9 low
    {4'd10, 4'd13, 4'd0,  32'h00001000, 32'h00000000, 32'h00000013}, // R10 zero count
    {4'd10, 4'd13, 4'd0,  32'h12345678, 32'h12345678, 32'h00000020}, // R10 identical
    {4'd10, 4'd13, 4'd0,  32'h80000000, 32'h00000000, 32'h00000000}, // R10 top differs
    {4'd11, 4'd14, 4'd0,  32'h11223344, 32'h00000000, 32'h44332211}, // R11
    {4'd12, 4'd15, 4'd0,  32'h00000000, 32'hDEADBEEF, 32'h00000000}, // R12 zero
    {4'd12, 4'd15, 4'd0,  32'h00000100, 32'hDEADBEEF, 32'hDEADBEEF}  // R12 pass
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] sh,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; shamt = sh; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 result in reset", out_result, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][103:100], VEC[i][99:96], VEC[i][95:64], VEC[i][63:32]);
      check($sformatf("R%0d vector %0d", VEC[i][107:104], i), out_result, VEC[i][31:0]);
      check("R2 valid after issue", {31'd0, out_valid}, 32'd1);
    end

    // R2: idle cycles with changed operands leave the result untouched
    issue(4'd14, 4'd0, 32'hCAFEF00D, 32'd0);
    check("R11 swap before idle", out_result, 32'h0DF0FECA);
    opcode = 4'd0; src_a = 32'h01010101; src_b = 32'h02020202;
    repeat (3) @(negedge clk);
    check("R2 result held while idle", out_result, 32'h0DF0FECA);
    check("R2 valid low while idle", {31'd0, out_valid}, 32'd0);

    // R5: shift by zero leaves the lanes intact
    issue(4'd6, 4'd0, 32'h8001FFFF, 32'd0);
    check("R5 shift zero", out_result, 32'h8001FFFF);

    // R1: reset clears a live result
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 result cleared", out_result, 32'd0);
    check("R1 valid cleared", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule